// File: doc/BRIEF.md
# Flash buffered program sequencer

This block drives the command and data cycles that a parallel NOR flash needs in order to program a short run of words through its on-chip write buffer. A host supplies a start word address and a length in bytes, then streams the data words through a valid/ready handshake. The sequencer writes the two unlock cycles, the buffer-load command, the word count, each data word and the confirm command. It then waits a programmable time, polls the flash status until the toggle bit settles or a pair limit runs out, and verifies the last programmed word.

The flash side is a plain synchronous strobe bus. A write strobe carries an address and a data word for one cycle. A read strobe carries an address for one cycle, and the flash returns read data during that same cycle. The bus width is a parameter of 8, 16 or 32 bits. Byte k of the host's stream travels in lane k mod (width/8) of word k div (width/8), and lane i occupies bits 8i+7..8i. If verification fails, the block writes the flash reset command to the chip base address before it reports the failure.

Top module: `nor_bufprog_seq`

## Requirements
- R1: A start with a nonzero length opens with a write of 0xAA to UNLOCK_A in the cycle after the start edge, followed in the next cycle by a write of 0x55 to UNLOCK_B.
- R2: The next two writes both go to the start address: first the buffer-load command 0x25, then the count word.
- R3: The count word is ceil(length/bytes-per-word) minus one. A length that is an exact multiple of the word size therefore gives words-1, and a length of 1 byte gives 0.
- R4: Data words are written in host order, one per accepted handshake, to consecutive word addresses starting at the start address. data_ready_o is high only while data words are still owed.
- R5: In a final word that is only partly covered by the length, every lane at or above the leftover byte count is written as 0xFF, whatever the host supplied in those lanes.
- R6: The confirm command 0x29 goes to the start address in the cycle after the last data write. Exactly wait_cycles_i idle bus cycles then pass before the first status read.
- R7: Status reads go to the address of the last data word, in pairs. Polling stops when bit 6 has the same value in both reads of a pair, or after poll_limit_i pairs (a limit of 0 acts as 1). Two verification reads follow, and the result passes only if both equal the last word written, padding included.
- R8: On a failed verification, the reset command 0xF0 is written to CHIP_BASE. Done with pass low follows in the next cycle.
- R9: busy_o rises in the cycle after an accepted start and falls in the cycle in which the one-cycle done_o pulse appears. A start while busy is ignored.
- R10: A start with length 0 produces done_o with pass_o high in the cycle after the start edge, with no bus cycle and no rise of busy_o.
- R11: After reset, busy_o, done_o, pass_o, data_ready_o and both bus strobes are low.
- R12: The write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| start_addr_i | input | AW | First word address, also used as the command address |
| byte_len_i | input | LENW | Number of bytes to program |
| wait_cycles_i | input | DLYW | Idle cycles between confirm and first status read |
| poll_limit_i | input | TOW | Maximum number of status read pairs |
| data_valid_i | input | 1 | Host data word available |
| data_i | input | DW | Host data word |
| data_ready_o | output | 1 | Sequencer accepts a data word |
| bus_we_o | output | 1 | Flash write strobe |
| bus_re_o | output | 1 | Flash read strobe |
| bus_addr_o | output | AW | Flash word address |
| bus_wdata_o | output | DW | Flash write data |
| bus_rdata_i | input | DW | Flash read data, valid in the read strobe cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid with done_o |

## Verification
The sequence is a fixed ordering of bus writes, so a state machine that skips a step, repeats a step or jumps early shows up on the very next write strobe. It appears there as a wrong address or a wrong data value compared with the expected command list. A wrong word counter or a wrong padding decision first appears as a bad count word, two data writes after the unlock pair, or as a final word with the wrong lanes. A wrong poll counter or wrong toggle comparison is seen later, as an extra or missing read strobe or a confirm-to-read gap that differs from the programmed delay. A wrong verdict is seen at done_o, together with the presence or absence of the reset write in the cycle before it.

// File: rtl/nor_bufprog_pkg.sv
package nor_bufprog_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNL2,
        S_LOAD,
        S_CNT,
        S_DATA,
        S_CONF,
        S_WAIT,
        S_P1,
        S_P2,
        S_F1,
        S_F2,
        S_ABORT
    } seq_state_t;

    localparam logic [7:0] CMD_KEY_A    = 8'hAA;
    localparam logic [7:0] CMD_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_BUF_LOAD = 8'h25;
    localparam logic [7:0] CMD_COMMIT   = 8'h29;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    localparam int TOGGLE_BIT = 6;

endpackage

// File: rtl/nor_bufprog_sizer.sv
// Turns a byte length into a data word count, the count-minus-one value
// sent to the flash, and the number of bytes in a trailing partial word.
module nor_bufprog_sizer #(
    parameter int DW   = 16,
    parameter int LENW = 10
) (
    input  logic [LENW-1:0] len_i,
    output logic [LENW-1:0] words_o,
    output logic [LENW-1:0] count_o,
    output logic [LENW-1:0] tail_o
);
    localparam int BYTES = DW / 8;
    localparam int SH    = $clog2(BYTES);
    localparam logic [LENW-1:0] LANE_MASK = LENW'(BYTES - 1);

    logic [LENW-1:0] full_words;
    logic            has_tail;

    always_comb begin
        full_words = len_i >> SH;
        tail_o     = len_i & LANE_MASK;
        has_tail   = |tail_o;
        words_o    = full_words + {{(LENW-1){1'b0}}, has_tail};
        count_o    = words_o - LENW'(1);
    end

endmodule

// File: rtl/nor_bufprog_pad.sv
// Replaces the lanes of a trailing partial word that carry no data with 0xFF.
module nor_bufprog_pad #(
    parameter int DW   = 16,
    parameter int LENW = 10
) (
    input  logic [DW-1:0]   word_i,
    input  logic            apply_i,
    input  logic [LENW-1:0] tail_i,
    output logic [DW-1:0]   word_o
);
    localparam int BYTES = DW / 8;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic keep;
        assign keep = !apply_i || (LENW'(g) < tail_i);
        assign word_o[8*g +: 8] = keep ? word_i[8*g +: 8] : 8'hFF;
    end

endmodule

// File: rtl/nor_bufprog_seq.sv
module nor_bufprog_seq
    import nor_bufprog_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 24,
    parameter int LENW = 10,
    parameter int DLYW = 16,
    parameter int TOW  = 16,
    parameter logic [AW-1:0] UNLOCK_A  = AW'('h555),
    parameter logic [AW-1:0] UNLOCK_B  = AW'('h2AA),
    parameter logic [AW-1:0] CHIP_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   start_addr_i,
    input  logic [LENW-1:0] byte_len_i,
    input  logic [DLYW-1:0] wait_cycles_i,
    input  logic [TOW-1:0]  poll_limit_i,
    input  logic            data_valid_i,
    input  logic [DW-1:0]   data_i,
    output logic            data_ready_o,
    output logic            bus_we_o,
    output logic            bus_re_o,
    output logic [AW-1:0]   bus_addr_o,
    output logic [DW-1:0]   bus_wdata_o,
    input  logic [DW-1:0]   bus_rdata_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            pass_o
);

    typedef struct packed {
        seq_state_t      st;
        logic [AW-1:0]   base;
        logic [AW-1:0]   addr;
        logic [LENW-1:0] len;
        logic [LENW-1:0] left;
        logic [DLYW-1:0] wait_cfg;
        logic [DLYW-1:0] dly;
        logic [TOW-1:0]  lim;
        logic [TOW-1:0]  polls;
        logic            tbit;
        logic [DW-1:0]   last_word;
        logic [DW-1:0]   first_rd;
        logic            we;
        logic            re;
        logic [AW-1:0]   baddr;
        logic [DW-1:0]   bdata;
        logic            done;
        logic            pass;
    } seq_t;

    seq_t q, d;

    logic [LENW-1:0] sz_words, sz_count, sz_tail;
    logic [DW-1:0]   padded;
    logic            pad_apply;

    nor_bufprog_sizer #(.DW(DW), .LENW(LENW)) u_sizer (
        .len_i   (q.len),
        .words_o (sz_words),
        .count_o (sz_count),
        .tail_o  (sz_tail)
    );

    assign pad_apply = (q.left == LENW'(1)) && (sz_tail != '0);

    nor_bufprog_pad #(.DW(DW), .LENW(LENW)) u_pad (
        .word_i  (data_i),
        .apply_i (pad_apply),
        .tail_i  (sz_tail),
        .word_o  (padded)
    );

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.re   = 1'b0;
        d.done = 1'b0;
        d.pass = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (byte_len_i == '0) begin
                        d.done = 1'b1;
                        d.pass = 1'b1;
                    end else begin
                        d.st       = S_UNL2;
                        d.base     = start_addr_i;
                        d.addr     = start_addr_i;
                        d.len      = byte_len_i;
                        d.wait_cfg = wait_cycles_i;
                        d.lim      = poll_limit_i;
                        d.polls    = '0;
                        d.we       = 1'b1;
                        d.baddr    = UNLOCK_A;
                        d.bdata    = DW'(CMD_KEY_A);
                    end
                end
            end
            S_UNL2: begin
                d.we    = 1'b1;
                d.baddr = UNLOCK_B;
                d.bdata = DW'(CMD_KEY_B);
                d.st    = S_LOAD;
            end
            S_LOAD: begin
                d.we    = 1'b1;
                d.baddr = q.base;
                d.bdata = DW'(CMD_BUF_LOAD);
                d.st    = S_CNT;
            end
            S_CNT: begin
                d.we    = 1'b1;
                d.baddr = q.base;
                d.bdata = DW'(sz_count);
                d.left  = sz_words;
                d.st    = S_DATA;
            end
            S_DATA: begin
                if (data_valid_i) begin
                    d.we        = 1'b1;
                    d.baddr     = q.addr;
                    d.bdata     = padded;
                    d.last_word = padded;
                    d.addr      = q.addr + AW'(1);
                    d.left      = q.left - LENW'(1);
                    if (q.left == LENW'(1)) begin
                        d.st = S_CONF;
                    end
                end
            end
            S_CONF: begin
                d.we    = 1'b1;
                d.baddr = q.base;
                d.bdata = DW'(CMD_COMMIT);
                d.dly   = q.wait_cfg;
                d.st    = S_WAIT;
            end
            S_WAIT: begin
                if (q.dly == '0) begin
                    d.re    = 1'b1;
                    d.baddr = q.addr - AW'(1);
                    d.st    = S_P1;
                end else begin
                    d.dly = q.dly - DLYW'(1);
                end
            end
            S_P1: begin
                d.tbit = bus_rdata_i[TOGGLE_BIT];
                d.re   = 1'b1;
                d.st   = S_P2;
            end
            S_P2: begin
                d.re    = 1'b1;
                d.polls = q.polls + TOW'(1);
                if ((bus_rdata_i[TOGGLE_BIT] == q.tbit) || (d.polls >= q.lim)) begin
                    d.st = S_F1;
                end else begin
                    d.st = S_P1;
                end
            end
            S_F1: begin
                d.first_rd = bus_rdata_i;
                d.re       = 1'b1;
                d.st       = S_F2;
            end
            S_F2: begin
                if ((q.first_rd == q.last_word) && (bus_rdata_i == q.last_word)) begin
                    d.done = 1'b1;
                    d.pass = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    d.we    = 1'b1;
                    d.baddr = CHIP_BASE;
                    d.bdata = DW'(CMD_RESET);
                    d.st    = S_ABORT;
                end
            end
            S_ABORT: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_ready_o = (q.st == S_DATA);
    assign busy_o       = (q.st != S_IDLE);
    assign bus_we_o     = q.we;
    assign bus_re_o     = q.re;
    assign bus_addr_o   = q.baddr;
    assign bus_wdata_o  = q.bdata;
    assign done_o       = q.done;
    assign pass_o       = q.pass;

endmodule

// File: rtl/nor_bufprog_seq_chk.sv
module nor_bufprog_seq_chk #(
    parameter int DW = 16,
    parameter int AW = 24,
    parameter logic [AW-1:0] CHIP_BASE = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_ready_o,
    input logic          bus_we_o,
    input logic          bus_re_o,
    input logic [AW-1:0] bus_addr_o,
    input logic [DW-1:0] bus_wdata_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          pass_o
);

    a_r12_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_o && bus_re_o));

    a_r4_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o |-> busy_o);

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r9_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o);

    a_r8_reset_before_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pass_o) |-> ($past(bus_we_o) && ($past(bus_addr_o) == CHIP_BASE)
                                 && ($past(bus_wdata_o) == DW'(8'hF0))));

endmodule

bind nor_bufprog_seq nor_bufprog_seq_chk #(
    .DW(DW), .AW(AW), .CHIP_BASE(CHIP_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_ready_o (data_ready_o),
    .bus_we_o     (bus_we_o),
    .bus_re_o     (bus_re_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pass_o       (pass_o)
);

// File: tb/tb_nor_bufprog_seq.sv
module tb_nor_bufprog_seq;
    localparam int DW    = 16;
    localparam int AW    = 24;
    localparam int LENW  = 10;
    localparam int DLYW  = 16;
    localparam int TOW   = 16;
    localparam int BYTES = DW / 8;
    localparam logic [AW-1:0] UA   = AW'('h555);
    localparam logic [AW-1:0] UB   = AW'('h2AA);
    localparam logic [AW-1:0] BASE = '0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   start_addr_i = '0;
    logic [LENW-1:0] byte_len_i = '0;
    logic [DLYW-1:0] wait_cycles_i = '0;
    logic [TOW-1:0]  poll_limit_i = '0;
    logic            data_valid_i = 1'b0;
    logic [DW-1:0]   data_i = '0;
    logic            data_ready_o;
    logic            bus_we_o, bus_re_o;
    logic [AW-1:0]   bus_addr_o;
    logic [DW-1:0]   bus_wdata_o;
    logic [DW-1:0]   bus_rdata_i;
    logic            busy_o, done_o, pass_o;

    nor_bufprog_seq #(.DW(DW), .AW(AW), .LENW(LENW), .DLYW(DLYW), .TOW(TOW),
                      .UNLOCK_A(UA), .UNLOCK_B(UB), .CHIP_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_len_i(byte_len_i), .wait_cycles_i(wait_cycles_i), .poll_limit_i(poll_limit_i),
        .data_valid_i(data_valid_i), .data_i(data_i), .data_ready_o(data_ready_o),
        .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
        bit            conf;
    } wr_t;

    wr_t           exp_q[$];
    logic [DW-1:0] host_q[$];
    int            n_checks = 0;
    int            n_errors = 0;
    int            cyc = 0;
    int            rd_idx = 0;
    int            tog_n = 0;
    logic [DW-1:0] final_val = '0;
    int            rd_seen = 0;
    int            conf_cyc = -1;
    int            first_rd_cyc = -1;
    logic [AW-1:0] poll_addr = '0;
    bit            stall_en = 1'b0;
    int            tick = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // flash status model: bit 6 toggles for tog_n reads, then a fixed value
    assign bus_rdata_i = (rd_idx < tog_n) ? ((rd_idx % 2 == 1) ? DW'(16'h0040) : DW'(0))
                                          : final_val;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (start_i && !busy_o) rd_idx <= 0;
        else if (bus_re_o)      rd_idx <= rd_idx + 1;
    end

    // host data source with optional stalls
    always @(posedge clk) begin
        tick <= tick + 1;
        if (data_valid_i && data_ready_o) void'(host_q.pop_front());
        if (host_q.size() > 0 && !(stall_en && (tick % 3 == 0))) begin
            data_valid_i <= 1'b1;
            data_i       <= host_q[0];
        end else begin
            data_valid_i <= 1'b0;
        end
    end

    // per-clock comparison against the expected bus activity
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_we_o && bus_re_o)
                check(1'b0, "R12", "both strobes", 1, 0);
            if (data_ready_o && !busy_o)
                check(1'b0, "R4", "ready while idle", 1, 0);
            if (bus_we_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected write addr", longint'(bus_addr_o), 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(bus_addr_o == e.a, e.tag, "write address",
                          longint'(bus_addr_o), longint'(e.a));
                    check(bus_wdata_o == e.d, e.tag, "write data",
                          longint'(bus_wdata_o), longint'(e.d));
                    if (e.conf) conf_cyc = cyc;
                end
            end
            if (bus_re_o) begin
                rd_seen++;
                if (rd_seen == 1) first_rd_cyc = cyc;
                check(bus_addr_o == poll_addr, "R7", "read address",
                      longint'(bus_addr_o), longint'(poll_addr));
            end
        end
    end

    task automatic run_op(input logic [AW-1:0] addr, input int len, input int w,
                          input int lim, input int tog, input bit exp_pass,
                          input int exp_reads, input bit stall, input bit poke);
        int nw;
        logic [DW-1:0] last;
        int t;
        nw   = (len + BYTES - 1) / BYTES;
        last = '0;
        exp_q.push_back('{UA, DW'(8'hAA), "R1", 1'b0});
        exp_q.push_back('{UB, DW'(8'h55), "R1", 1'b0});
        exp_q.push_back('{addr, DW'(8'h25), "R2", 1'b0});
        exp_q.push_back('{addr, DW'(nw - 1), "R3", 1'b0});
        for (int j = 0; j < nw; j++) begin
            logic [DW-1:0] hw, pw;
            for (int l = 0; l < BYTES; l++) begin
                int k;
                logic [7:0] b;
                k = j * BYTES + l;
                b = 8'h31 + 8'(k * 23);
                hw[8*l +: 8] = (k < len) ? b : 8'hA5;
                pw[8*l +: 8] = (k < len) ? b : 8'hFF;
            end
            host_q.push_back(hw);
            exp_q.push_back('{addr + AW'(j), pw,
                              ((j == nw - 1) && (len % BYTES != 0)) ? "R5" : "R4", 1'b0});
            last = pw;
        end
        exp_q.push_back('{addr, DW'(8'h29), "R6", 1'b1});
        if (!exp_pass) exp_q.push_back('{BASE, DW'(8'hF0), "R8", 1'b0});
        tog_n        = tog;
        final_val    = exp_pass ? last : (last ^ DW'(1));
        poll_addr    = addr + AW'(nw - 1);
        rd_seen      = 0;
        conf_cyc     = -1;
        first_rd_cyc = -1;
        stall_en     = stall;

        @(negedge clk);
        start_addr_i  = addr;
        byte_len_i    = LENW'(len);
        wait_cycles_i = DLYW'(w);
        poll_limit_i  = TOW'(lim);
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", longint'(busy_o), 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            start_addr_i = AW'('h7777);
            byte_len_i   = LENW'(3);
            start_i      = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (!done_o && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(t < 3000, "R9", "done arrives", t, 0);
        check(pass_o == exp_pass, exp_pass ? "R7" : "R8", "pass flag",
              longint'(pass_o), longint'(exp_pass));
        check(busy_o == 1'b0, "R9", "busy low at done", longint'(busy_o), 0);
        check(exp_q.size() == 0, "R9", "writes outstanding", exp_q.size(), 0);
        check(host_q.size() == 0, "R4", "host words left", host_q.size(), 0);
        check(rd_seen == exp_reads, "R7", "read count", rd_seen, exp_reads);
        check(first_rd_cyc - conf_cyc - 1 == w, "R6", "confirm-to-read gap",
              first_rd_cyc - conf_cyc - 1, w);
        @(negedge clk);
        check(done_o == 1'b0, "R9", "done is one cycle", longint'(done_o), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !pass_o, "R11", "status after reset",
              longint'({busy_o, done_o, pass_o}), 0);
        check(!bus_we_o && !bus_re_o && !data_ready_o, "R11", "strobes after reset",
              longint'({bus_we_o, bus_re_o, data_ready_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 7 bytes: 3 full words plus a one-byte tail, host stalls, passes after toggling
        run_op(AW'('h1000), 7, 3, 20, 4, 1'b1, 8, 1'b1, 1'b0);
        // 6 bytes exact multiple, toggling never stops, pair limit 3, fails; start poked while busy
        run_op(AW'('h2000), 6, 0, 3, 100000, 1'b0, 8, 1'b0, 1'b1);
        // 1 byte only, status settles at once but holds a wrong value
        run_op(AW'('h3001), 1, 1, 5, 0, 1'b0, 4, 1'b0, 1'b0);
        // 2 bytes (one full word, count 0), one toggling pair then success
        run_op(AW'('h0040), 2, 2, 5, 2, 1'b1, 6, 1'b1, 1'b0);

        // R10: zero length completes at once without bus cycles
        @(negedge clk);
        byte_len_i = '0;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && pass_o, "R10", "zero length done/pass",
              longint'({done_o, pass_o}), 3);
        check(!busy_o, "R10", "zero length never busy", longint'(busy_o), 0);
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R10", "zero length quiet after",
              longint'({busy_o, done_o}), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule